// File: doc/BRIEF.md
# CAN Card Host-Bus Glue and Interrupt Bridge

This block connects a host I/O bus to one byte-wide CAN controller core on a plug-in card. The host reaches three independent I/O windows, each with its own chip select. The bridge window holds a single 32-bit interrupt control/status word. The controller window passes byte accesses through to the CAN core. The identification window returns a fixed version byte. All other offsets in every window read as zero and ignore writes.

The core's interrupt line is gated by a software enable bit in the control/status word, and the result drives the host interrupt request. When the host reads the control/status word, its status bit reports the live core interrupt level rather than a stored value. A forwarded core access is a one-cycle strobe. The core returns its byte in the same cycle, and the block registers it onto the host read bus. All host read data appears one cycle after the read strobe and is zero when no read is in progress. During device reset the block holds the CAN core in hardware reset.

Top module: `canbg_glue`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0, `host_irq` is 0 and `core_rst` is 1. `core_rst` falls at the first rising clock edge after `rst_n` goes high. Reset clears the control/status word to 0.
- R2: All read results appear on `rdata` in the cycle after the read strobe. A cycle with no read leaves `rdata` at 0.
- R3: In the bridge window, a word write at byte offset 0x38 stores all 32 bits of `wdata`. A read at 0x38 returns the stored word, except that bit 23 shows the current `core_irq` level.
- R4: In the bridge window, every offset other than 0x38 reads 0. Writes to those offsets leave the control/status word unchanged.
- R5: `host_irq` equals `core_irq` AND bit 13 of the stored control/status word. It changes in the same cycle as `core_irq`. It follows a written enable value from the clock edge that stores the write.
- R6: In the controller window, accesses at offsets 0x00 to 0x1F produce `core_stb` with `core_addr` equal to the offset. Writes carry `wdata[7:0]`, and reads return the core byte in `rdata[7:0]` with the upper bits zero.
- R7: In the controller window, offsets 0x20 to 0x7F never assert `core_stb` and read 0.
- R8: In the identification window, offset 7 reads 0xD0 (version 13 in the high nibble). Every other offset reads 0, and writes have no effect.
- R9: If more than one chip select is active, the bridge window takes priority over the controller window, and the controller window over the identification window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous device reset |
| sel_bridge | input | 1 | Chip select, bridge register window |
| sel_ctrl | input | 1 | Chip select, controller window |
| sel_id | input | 1 | Chip select, identification window |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 7 | Byte offset within the selected window |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Interrupt request to the host |
| core_rst | output | 1 | Hardware reset to the CAN core |
| core_stb | output | 1 | One-cycle access strobe to the core |
| core_we | output | 1 | Core access is a write |
| core_addr | output | 5 | Core register offset |
| core_wdata | output | 8 | Core write byte |
| core_rdata | input | 8 | Core read byte, valid during the strobe |
| core_irq | input | 1 | Interrupt level from the core |

## Verification
The bench uses the default configuration: a 7-bit window offset, a 32-byte core span and an 8-byte identification window. With these values, every offset of all three windows can be swept on both reads and writes. Out-of-range controller writes are checked for aliasing onto in-range core bytes by reading back a bench-side core model. All four combinations of enable and core interrupt level are driven, including enable flips while an interrupt is pending.

// File: rtl/canbg_pkg.sv
package canbg_pkg;
    localparam int unsigned HOST_DW = 32;
    localparam int unsigned CORE_DW = 8;

    typedef struct packed {
        logic [HOST_DW-1:0] rdata;
        logic               core_rst;
    } glue_st_t;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_BRIDGE = 2'd1,
        WIN_CTRL   = 2'd2,
        WIN_ID     = 2'd3
    } win_e;
endpackage

// File: rtl/canbg_csr.sv
module canbg_csr #(
    parameter int unsigned DW       = 32,
    parameter int unsigned EN_BIT   = 13,
    parameter int unsigned STAT_BIT = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          core_irq,
    output logic [DW-1:0] rd_word,
    output logic          host_irq
);
    typedef struct packed {
        logic [DW-1:0] word;
    } csr_st_t;

    csr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word           = st_q.word;
        rd_word[STAT_BIT] = core_irq;
    end

    assign host_irq = core_irq & st_q.word[EN_BIT];
endmodule

// File: rtl/canbg_core_port.sv
module canbg_core_port #(
    parameter int unsigned AW        = 7,
    parameter int unsigned CORE_SPAN = 32,
    localparam int unsigned CAW      = $clog2(CORE_SPAN)
) (
    input  logic           acc,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [7:0]     wdata,
    input  logic [7:0]     core_rdata,
    output logic           core_stb,
    output logic           core_we,
    output logic [CAW-1:0] core_addr,
    output logic [7:0]     core_wdata,
    output logic [7:0]     rd_byte
);
    logic in_span;

    assign in_span    = (32'(addr) < CORE_SPAN);
    assign core_stb   = acc & in_span & (rd_en | wr_en);
    assign core_we    = core_stb & wr_en;
    assign core_addr  = addr[CAW-1:0];
    assign core_wdata = wdata;
    assign rd_byte    = (core_stb && rd_en) ? core_rdata : 8'h00;
endmodule

// File: rtl/canbg_id_rom.sv
module canbg_id_rom #(
    parameter int unsigned AW      = 7,
    parameter int unsigned ID_SPAN = 8,
    parameter int unsigned ID_OFS  = 7,
    parameter int unsigned VERSION = 13
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_byte
);
    localparam logic [7:0] ID_BYTE = {4'(VERSION), 4'h0};

    generate
        if (ID_OFS < ID_SPAN) begin : g_rom
            assign rd_byte = (32'(addr) == ID_OFS) ? ID_BYTE : 8'h00;
        end else begin : g_empty
            assign rd_byte = 8'h00;
        end
    endgenerate
endmodule

// File: rtl/canbg_glue.sv
module canbg_glue #(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned CSR_OFS   = 56,
    parameter int unsigned EN_BIT    = 13,
    parameter int unsigned STAT_BIT  = 23,
    parameter int unsigned CORE_SPAN = 32,
    parameter int unsigned ID_SPAN   = 8,
    parameter int unsigned ID_OFS    = 7,
    parameter int unsigned VERSION   = 13,
    localparam int unsigned DW       = canbg_pkg::HOST_DW,
    localparam int unsigned CAW      = $clog2(CORE_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_bridge,
    input  logic              sel_ctrl,
    input  logic              sel_id,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              host_irq,
    output logic              core_rst,
    output logic              core_stb,
    output logic              core_we,
    output logic [CAW-1:0]    core_addr,
    output logic [7:0]        core_wdata,
    input  logic [7:0]        core_rdata,
    input  logic              core_irq
);
    import canbg_pkg::*;

    win_e          win;
    logic          csr_hit;
    logic [DW-1:0] csr_word;
    logic [7:0]    ctrl_byte;
    logic [7:0]    id_byte;
    glue_st_t      st_d, st_q;

    always_comb begin
        if (sel_bridge)    win = WIN_BRIDGE;
        else if (sel_ctrl) win = WIN_CTRL;
        else if (sel_id)   win = WIN_ID;
        else               win = WIN_NONE;
    end

    assign csr_hit = (win == WIN_BRIDGE) && (32'(addr) == CSR_OFS);

    canbg_csr #(.DW(DW), .EN_BIT(EN_BIT), .STAT_BIT(STAT_BIT)) csr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (csr_hit & wr_en),
        .wdata    (wdata),
        .core_irq (core_irq),
        .rd_word  (csr_word),
        .host_irq (host_irq)
    );

    canbg_core_port #(.AW(ADDR_W), .CORE_SPAN(CORE_SPAN)) port_i (
        .acc        (win == WIN_CTRL),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata[7:0]),
        .core_rdata (core_rdata),
        .core_stb   (core_stb),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .rd_byte    (ctrl_byte)
    );

    canbg_id_rom #(.AW(ADDR_W), .ID_SPAN(ID_SPAN), .ID_OFS(ID_OFS),
                   .VERSION(VERSION)) id_i (
        .addr    (addr),
        .rd_byte (id_byte)
    );

    always_comb begin
        st_d          = st_q;
        st_d.core_rst = 1'b0;
        st_d.rdata    = '0;
        if (rd_en) begin
            unique case (win)
                WIN_BRIDGE: st_d.rdata = csr_hit ? csr_word : '0;
                WIN_CTRL:   st_d.rdata = DW'(ctrl_byte);
                WIN_ID:     st_d.rdata = DW'(id_byte);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rdata    <= '0;
            st_q.core_rst <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign core_rst = st_q.core_rst;
endmodule

// File: rtl/canbg_glue_chk.sv
module canbg_glue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_bridge,
    input logic        sel_ctrl,
    input logic        sel_id,
    input logic        rd_en,
    input logic        wr_en,
    input logic [6:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        host_irq,
    input logic        core_rst,
    input logic        core_stb,
    input logic [4:0]  core_addr,
    input logic        core_irq
);
    // R5
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> core_irq);

    // R5
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_bridge && addr == 7'h38 && wdata[13])
        |=> (!core_irq || host_irq));

    // R7
    stb_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_stb |-> (sel_ctrl && !sel_bridge && addr < 7'd32
                      && core_addr == addr[4:0]));

    // R8
    id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_id && !sel_ctrl && !sel_bridge && addr == 7'd7)
        |=> rdata == 32'h0000_00D0);

    // R4
    bridge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_bridge && addr != 7'h38) |=> rdata == 32'h0);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == 32'h0);

    // R1
    core_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !core_rst);
endmodule

bind canbg_glue canbg_glue_chk chk_i (.*);

// File: tb/canbg_glue_tb_top.sv
module canbg_glue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_bridge = 1'b0, sel_ctrl = 1'b0, sel_id = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        host_irq, core_rst, core_stb, core_we;
    logic [4:0]  core_addr;
    logic [7:0]  core_wdata, core_rdata;
    logic        core_irq = 1'b0;
    logic [7:0]  cmem [32];
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    canbg_glue dut_i (.*);

    assign core_rdata = cmem[core_addr];
    always @(posedge clk) if (core_stb && core_we) cmem[core_addr] <= core_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input int win, input logic wr, input logic [6:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        sel_bridge = (win == 0); sel_ctrl = (win == 1); sel_id = (win == 2);
        rd_en = !wr; wr_en = wr; addr = a; wdata = d;
        @(posedge clk); #1;
        sel_bridge = 0; sel_ctrl = 0; sel_id = 0; rd_en = 0; wr_en = 0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) cmem[i] = 8'h00;
        core_irq = 1'b1;
        #22;
        check("R1 rdata", rdata, 0);
        check("R1 host_irq", {31'b0, host_irq}, 0);
        check("R1 core_rst", {31'b0, core_rst}, 1);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 core_rst release", {31'b0, core_rst}, 0);
        access(0, 0, 7'h38, 0);
        check("R1 csr cleared", rdata, 32'h0080_0000);
        core_irq = 1'b0;

        // R8 identification window sweep
        for (int a = 0; a < 128; a++) begin
            access(2, 1, 7'(a), 32'hFF);
            access(2, 0, 7'(a), 0);
            check("R8 id", rdata, (a == 7) ? 32'hD0 : 0);
        end
        // R6 in-range core writes
        for (int a = 0; a < 32; a++) access(1, 1, 7'(a), 32'hAB00 | (a ^ 8'h5A));
        // R7 out-of-range writes must not alias
        for (int a = 32; a < 128; a++) access(1, 1, 7'(a), 32'hEE);
        for (int a = 0; a < 128; a++) begin
            access(1, 0, 7'(a), 0);
            check(a < 32 ? "R6 core read" : "R7 out of span", rdata,
                  a < 32 ? 32'(a ^ 8'h5A) : 0);
        end
        // R4 bridge other offsets
        for (int a = 0; a < 128; a += 4) if (a != 56) access(0, 1, 7'(a), 32'hFFFF_FFFF);
        access(0, 0, 7'h38, 0);
        check("R4 csr untouched", rdata, 0);
        for (int a = 0; a < 128; a += 4) if (a != 56) begin
            access(0, 0, 7'(a), 0);
            check("R4 bridge zero", rdata, 0);
        end
        // R2 idle cycle returns zero
        access(2, 0, 7'd7, 0);
        @(posedge clk); #1;
        check("R2 idle", rdata, 0);
        // R3 store and live status
        access(0, 1, 7'h38, 32'hA5A5_5A5A);
        access(0, 0, 7'h38, 0);
        check("R3 status live low", rdata, 32'hA525_5A5A);
        core_irq = 1'b1; #1;
        access(0, 0, 7'h38, 0);
        check("R3 status live high", rdata, 32'hA5A5_5A5A);
        // R5 gating in all combinations
        for (int e = 0; e < 2; e++) for (int q = 0; q < 2; q++) begin
            core_irq = 1'b0;
            access(0, 1, 7'h38, e ? 32'h0080_2000 : 32'h0080_0000);
            @(negedge clk); core_irq = q[0]; #1;
            check("R5 gate", {31'b0, host_irq}, (e == 1 && q == 1) ? 1 : 0);
        end
        // R5 enable flips with interrupt pending
        access(0, 1, 7'h38, 0);
        check("R5 disable", {31'b0, host_irq}, 0);
        access(0, 1, 7'h38, 32'h2000);
        check("R5 enable", {31'b0, host_irq}, 1);
        // R9 priority: bridge over controller over id
        @(negedge clk);
        sel_bridge = 1; sel_ctrl = 1; sel_id = 1; rd_en = 1; addr = 7'h38;
        @(posedge clk); #1;
        check("R9 bridge first", rdata, 32'h0080_2000);
        sel_bridge = 0; addr = 7'd7;
        @(posedge clk); #1;
        check("R9 ctrl over id", rdata, 32'(7 ^ 8'h5A));
        sel_ctrl = 0; sel_id = 0; rd_en = 0;
        // R1 mid-run reset clears enable
        @(negedge clk); rst_n = 1'b0; #1;
        check("R1 reset irq", {31'b0, host_irq}, 0);
        check("R1 reset core", {31'b0, core_rst}, 1);
        @(negedge clk); rst_n = 1'b1;
        access(0, 0, 7'h38, 0);
        check("R1 csr after reset", rdata, 32'h0080_0000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule